// File: doc/BRIEF.md
# Stack Processor Opcode Decoder

This block sits in the front end of a 32-bit zero-operand stack processor. Each clock that the fetch logic marks an opcode byte as valid, the block sorts it into an instruction class. It also produces the side data that the execute stage needs: a stack-slot index and byte offset, an immediate value, or a software trap vector with its return address. The execute stage performs the operation. Memory traffic is handled elsewhere.

Immediates are built from runs of prefix bytes. Each byte with its top bit set carries 7 payload bits. The first byte of a run is sign-extended. Each later byte of the same run shifts the current top of stack left by 7 and appends its own payload. While a run is open, the block holds off interrupts so that a run cannot be split.

Opcodes in the emulatable range can be marked for software handling by a mask supplied from outside. The configuration opcode produces a replacement mask that selects either the reduced or the complete instruction set. Every result is registered and appears one cycle after the strobe.

Top module: `stack_op_decoder`

## Requirements
- R1: After reset, `dec_valid` is 0, `dec_class` is 0 (none) and `irq_hold` is 0.
- R2: A valid opcode of 0x80 or above, while no immediate run is open, gives class 1 and `dec_imm` equal to bits 6:0 sign-extended from bit 6. It opens a run.
- R3: A valid opcode of 0x80 or above, while a run is open, gives class 2 and `dec_imm` = (`tos` << 7) | (opcode & 0x7F), truncated to 32 bits.
- R4: Any valid opcode below 0x80 closes the run, and a cycle with `op_valid` low leaves it unchanged. `irq_hold` is 1 exactly while a run is open.
- R5: Opcodes 16 to 31 give class 3 with `dec_slot` = opcode − 16 and `dec_slot_off` = 4 × `dec_slot`.
- R6: Opcodes 64 to 95 give class 4 and opcodes 96 to 127 give class 5. In both cases `dec_slot` = (opcode − base) XOR 16 and `dec_slot_off` = 4 × `dec_slot`.
- R7: An opcode from 32 to 63, other than 58, whose bit in `emu_mask` (indexed by opcode) is 1 gives class 6. `dec_vector` = (opcode − 32) × 32 + 0 and `dec_ret_pc` = `pc` + 1.
- R8: Opcode 0 gives class 7 (breakpoint).
- R9: Opcodes 1, 3, 14, 15, 32 and 33, when not taken by R7, give class 8 (illegal).
- R10: Opcode 58 always gives class 9. If `tos` = 0, `cfg_we` is 1 and `cfg_mask` is all ones except bits 36, 38, 41, 46, 49, 51, 52, 56, 61 and 63. If `tos` = 1, `cfg_we` is 1 and `cfg_mask` is 0. For any other `tos`, `cfg_we` is 0.
- R11: Every other opcode below 128 (2, 4 to 13, and 34 to 63 not taken by R7) gives class 10 (native).
- R12: Outputs are registered. A strobed opcode shows on the outputs in the next cycle, and a cycle with `op_valid` low yields `dec_valid` 0 and class 0 in the next cycle. Fields that do not apply to the class are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Opcode byte |
| tos | input | 32 | Current top-of-stack value |
| pc | input | 32 | Address of the opcode |
| emu_mask | input | 64 | Per-opcode software-emulation enables |
| dec_valid | output | 1 | Decoded result present |
| dec_class | output | 4 | Instruction class code |
| dec_slot | output | 5 | Stack slot index |
| dec_slot_off | output | 7 | Slot byte offset from SP |
| dec_imm | output | 32 | Immediate value to push or replace with |
| dec_vector | output | 32 | Software trap target |
| dec_ret_pc | output | 32 | Return address to push for a trap |
| irq_hold | output | 1 | Interrupt inhibit while a run is open |
| cfg_we | output | 1 | Replacement mask available |
| cfg_mask | output | 64 | Replacement emulation mask |

## Verification
The embedded assertions are checked on every clock. They cover the following:
- `irq_hold` agrees with the class of the last decoded immediate.
- An extension class only ever follows an open run.
- Idle cycles leave the run state untouched.
- Trap vectors keep their 32-byte stride alignment.
- `cfg_we` only ever comes with the configuration class.

The bench's scenarios and its reference model are what show the arithmetic:
- the sign extension at both ends of the 7-bit range;
- accumulation of the payload across several prefix bytes;
- the XOR-folded slot numbering;
- the exact reduced-set mask;
- the choice between a trap and illegal or native for each mask setting.

// File: rtl/stack_op_decoder.sv
module stack_op_decoder #(
  parameter int DW = 32,
  parameter int MASK_W = 64,
  parameter logic [31:0] VEC_BASE = 32'h0,
  parameter int VEC_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [DW-1:0]     tos,
  input  logic [DW-1:0]     pc,
  input  logic [MASK_W-1:0] emu_mask,
  output logic              dec_valid,
  output logic [3:0]        dec_class,
  output logic [4:0]        dec_slot,
  output logic [6:0]        dec_slot_off,
  output logic [DW-1:0]     dec_imm,
  output logic [DW-1:0]     dec_vector,
  output logic [DW-1:0]     dec_ret_pc,
  output logic              irq_hold,
  output logic              cfg_we,
  output logic [MASK_W-1:0] cfg_mask
);

  localparam logic [3:0] C_NONE = 4'd0, C_IMM = 4'd1, C_EXT = 4'd2, C_ADD = 4'd3,
                         C_ST = 4'd4, C_LD = 4'd5, C_EMU = 4'd6, C_BRK = 4'd7,
                         C_ILL = 4'd8, C_CFG = 4'd9, C_NAT = 4'd10;
  localparam logic [7:0] OP_CFG = 8'd58;

  function automatic logic [MASK_W-1:0] reduced_mask();
    logic [MASK_W-1:0] m;
    m = '1;
    foreach (m[i])
      if (i == 36 || i == 38 || i == 41 || i == 46 || i == 49 ||
          i == 51 || i == 52 || i == 56 || i == 61 || i == 63)
        m[i] = 1'b0;
    return m;
  endfunction

  localparam logic [MASK_W-1:0] MIN_MASK = reduced_mask();

  logic in_run;

  wire is_imm   = opcode[7];
  wire is_add   = opcode[7:4] == 4'b0001;
  wire is_st    = opcode[7:5] == 3'b010;
  wire is_ld    = opcode[7:5] == 3'b011;
  wire emu_rng  = opcode[7:5] == 3'b001;
  wire emu_hit  = emu_rng && opcode != OP_CFG && emu_mask[opcode[5:0]];
  wire is_nat   = (opcode inside {8'd2, [8'd4:8'd13]}) || (emu_rng && opcode >= 8'd34);

  logic [3:0] n_class;
  always_comb begin
    if (is_imm)                 n_class = in_run ? C_EXT : C_IMM;
    else if (is_add)            n_class = C_ADD;
    else if (is_st)             n_class = C_ST;
    else if (is_ld)             n_class = C_LD;
    else if (opcode == 8'd0)    n_class = C_BRK;
    else if (opcode == OP_CFG)  n_class = C_CFG;
    else if (emu_hit)           n_class = C_EMU;
    else if (is_nat)            n_class = C_NAT;
    else                        n_class = C_ILL;
  end

  wire [DW-1:0] imm_new = {{(DW-7){opcode[6]}}, opcode[6:0]};
  wire [DW-1:0] imm_ext = {tos[DW-8:0], opcode[6:0]};
  wire [4:0]    n_slot  = is_add ? {1'b0, opcode[3:0]} : (opcode[4:0] ^ 5'h10);
  wire [DW-1:0] n_vec   = VEC_BASE[DW-1:0] + ({{(DW-5){1'b0}}, opcode[4:0]} << VEC_SHIFT);
  wire          cfg_sel = (tos == '0) || (tos == {{(DW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_run     <= 1'b0;
      dec_valid  <= 1'b0;
      dec_class  <= C_NONE;
      dec_slot   <= '0;
      dec_imm    <= '0;
      dec_vector <= '0;
      dec_ret_pc <= '0;
      cfg_we     <= 1'b0;
      cfg_mask   <= '0;
    end else begin
      if (op_valid) in_run <= is_imm;
      dec_valid  <= op_valid;
      dec_class  <= op_valid ? n_class : C_NONE;
      dec_slot   <= (op_valid && (n_class == C_ADD || n_class == C_ST || n_class == C_LD)) ? n_slot : '0;
      dec_imm    <= (op_valid && n_class == C_IMM) ? imm_new :
                    (op_valid && n_class == C_EXT) ? imm_ext : '0;
      dec_vector <= (op_valid && n_class == C_EMU) ? n_vec : '0;
      dec_ret_pc <= (op_valid && n_class == C_EMU) ? pc + 1'b1 : '0;
      cfg_we     <= op_valid && n_class == C_CFG && cfg_sel;
      cfg_mask   <= (op_valid && n_class == C_CFG && tos == '0) ? MIN_MASK : '0;
    end
  end

  assign dec_slot_off = {dec_slot, 2'b00};
  assign irq_hold     = in_run;

  a_r4_hold_on_imm: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (dec_class == C_IMM || dec_class == C_EXT) |-> irq_hold);
  a_r4_free_after_other: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_class != C_IMM && dec_class != C_EXT |-> !irq_hold);
  a_r4_idle_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(irq_hold));
  a_r3_ext_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode[7] && irq_hold |=> dec_class == C_EXT);
  a_r12_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> dec_class == C_NONE && !cfg_we);
  a_r7_vector_stride: assert property (@(posedge clk) disable iff (!rst_n)
    dec_class == C_EMU |-> dec_vector[VEC_SHIFT-1:0] == VEC_BASE[VEC_SHIFT-1:0]);
  a_r10_we_only_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> dec_class == C_CFG);

endmodule

// File: tb/sim_stack_op_decoder.sv
`timescale 1ns/1ps
module sim_stack_op_decoder;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [7:0] opcode = 0;
  logic [31:0] tos = 0, pc = 0;
  logic [63:0] emu_mask = 0;
  logic dec_valid, irq_hold, cfg_we;
  logic [3:0] dec_class;
  logic [4:0] dec_slot;
  logic [6:0] dec_slot_off;
  logic [31:0] dec_imm, dec_vector, dec_ret_pc;
  logic [63:0] cfg_mask;

  always #10 clk = ~clk;

  stack_op_decoder u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .tos(tos), .pc(pc), .emu_mask(emu_mask), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_slot(dec_slot), .dec_slot_off(dec_slot_off), .dec_imm(dec_imm),
    .dec_vector(dec_vector), .dec_ret_pc(dec_ret_pc), .irq_hold(irq_hold),
    .cfg_we(cfg_we), .cfg_mask(cfg_mask));

  int total = 0, bad = 0;
  bit m_run = 0;
  int e_cls, e_slot;
  logic [31:0] e_imm, e_vec, e_ret;
  bit e_valid, e_we, e_hold;
  logic [63:0] e_mask;
  logic [63:0] all_ones = '1;

  function automatic logic [63:0] min_mask();
    int clr[10] = '{36, 38, 41, 46, 49, 51, 52, 56, 61, 63};
    logic [63:0] m = '1;
    foreach (clr[k]) m[clr[k]] = 0;
    return m;
  endfunction

  task automatic model(input bit v, input int op, input logic [31:0] t,
                       input logic [31:0] p, input logic [63:0] msk);
    e_valid = v; e_cls = 0; e_slot = 0; e_imm = 0; e_vec = 0; e_ret = 0; e_we = 0; e_mask = 0;
    if (v) begin
      if (op >= 128) begin
        if (m_run) begin e_cls = 2; e_imm = (t << 7) | (op & 127); end
        else begin e_cls = 1; e_imm = 32'(op & 127) - ((op & 64) != 0 ? 128 : 0); end
      end else if (op >= 16 && op < 32) begin e_cls = 3; e_slot = op - 16; end
      else if (op >= 64 && op < 96) begin e_cls = 4; e_slot = (op - 64) ^ 16; end
      else if (op >= 96) begin e_cls = 5; e_slot = (op - 96) ^ 16; end
      else if (op == 0) e_cls = 7;
      else if (op == 58) begin
        e_cls = 9;
        if (t == 0) begin e_we = 1; e_mask = min_mask(); end
        else if (t == 1) e_we = 1;
      end else if (op >= 32 && msk[op]) begin
        e_cls = 6; e_vec = (op - 32) * 32; e_ret = p + 1;
      end else if (op == 1 || op == 3 || op == 14 || op == 15 || op == 32 || op == 33) e_cls = 8;
      else e_cls = 10;
      m_run = (op >= 128);
    end
    e_hold = m_run;
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input int op, input logic [31:0] t,
                      input logic [31:0] p, input logic [63:0] msk);
    op_valid = v; opcode = 8'(op); tos = t; pc = p; emu_mask = msk;
    model(v, op, t, p, msk);
    @(posedge clk); @(negedge clk);
    total++;
    chk(tag, "valid", 64'(dec_valid), 64'(e_valid));
    chk(tag, "class", 64'(dec_class), 64'(e_cls));
    chk(tag, "slot", 64'(dec_slot), 64'(e_slot));
    chk(tag, "slot_off", 64'(dec_slot_off), 64'(e_slot * 4));
    chk(tag, "imm", 64'(dec_imm), 64'(e_imm));
    chk(tag, "vector", 64'(dec_vector), 64'(e_vec));
    chk(tag, "ret_pc", 64'(dec_ret_pc), 64'(e_ret));
    chk(tag, "irq_hold", 64'(irq_hold), 64'(e_hold));
    chk(tag, "cfg_we", 64'(cfg_we), 64'(e_we));
    chk(tag, "cfg_mask", cfg_mask, e_mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    // R1 reset state
    chk("R1", "valid", 64'(dec_valid), 0);
    chk("R1", "class", 64'(dec_class), 0);
    chk("R1", "irq_hold", 64'(irq_hold), 0);
    // R2 single immediates, both sign ends
    step("R2", 1, 8'h80, 32'h5, 0, 0);
    step("R4", 1, 11, 0, 0, 0);
    step("R2", 1, 8'hFF, 0, 0, 0);
    step("R4", 1, 11, 0, 0, 0);
    step("R2", 1, 8'hBF, 0, 0, 0);
    step("R4", 1, 5, 0, 0, 0);
    step("R2", 1, 8'hC0, 0, 0, 0);
    // R3 chained extension, with idle gap held by R4
    step("R3", 1, 8'h81, 32'hFFFF_FFC0, 0, 0);
    step("R4", 0, 8'h00, 0, 0, 0);
    step("R3", 1, 8'hFF, 32'h0123_4567, 0, 0);
    step("R3", 1, 8'h80, 32'hFFFF_FFFF, 0, 0);
    step("R4", 1, 16, 0, 0, 0);
    step("R2", 1, 8'h85, 0, 0, 0);
    // R5 add-slot range
    for (int o = 16; o < 32; o++) step("R5", 1, o, 0, 0, 0);
    // R6 store and load slot ranges
    for (int o = 64; o < 128; o++) step("R6", 1, o, 0, 0, 0);
    // R8 breakpoint, R9 illegal, R11 native with empty mask
    step("R8", 1, 0, 0, 0, 0);
    step("R9", 1, 1, 0, 0, 0);
    step("R9", 1, 3, 0, 0, 0);
    step("R9", 1, 14, 0, 0, 0);
    step("R9", 1, 15, 0, 0, 0);
    step("R9", 1, 32, 0, 0, 0);
    step("R9", 1, 33, 0, 0, 0);
    for (int o = 2; o < 14; o++) if (o != 3) step("R11", 1, o, 0, 0, 0);
    for (int o = 34; o < 64; o++) if (o != 58) step("R11", 1, o, 0, 0, 0);
    // R7 all emulatable opcodes trapped with a full mask
    for (int o = 32; o < 64; o++) step("R7", 1, o, 32'h7, 32'h1000 + o, all_ones);
    step("R7", 1, 63, 32'h7, 32'hFFFF_FFFF, all_ones);
    // R7 and R11 under the reduced mask
    for (int o = 32; o < 64; o++) step("R7", 1, o, 32'h9, 32'h40, min_mask());
    // R10 configuration
    step("R10", 1, 58, 0, 0, 0);
    step("R10", 1, 58, 1, 0, all_ones);
    step("R10", 1, 58, 5, 0, 0);
    step("R10", 1, 58, 32'hFFFF_FFFF, 0, all_ones);
    // R12 idle output after activity
    step("R12", 1, 8'h90, 0, 0, 0);
    step("R12", 0, 8'h44, 0, 0, all_ones);
    step("R12", 0, 0, 0, 0, 0);
    // R4 config and breakpoint close a run
    step("R3", 1, 8'h91, 32'h3, 0, 0);
    step("R4", 1, 58, 1, 0, 0);
    step("R2", 1, 8'h90, 0, 0, 0);
    step("R4", 1, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule